// File: doc/BRIEF.md
# Interrupt Destination Matcher

This block sits beside a group of local interrupt units and decides which of them accept an inter-processor message. For each unit it combines the unit's 8-bit ID, its logical ID, its destination-format model and an "is-source" flag with the message's destination byte, destination-mode bit and shorthand field, and produces a per-unit hit bit. The evaluation is combinational, so a hit is available in the same cycle that the message is presented.

Every unit holds its own destination-format register. Only the model nibble in bits 31:28 can be written. The remaining bits always read as ones.

When the message asks for lowest-priority delivery, a round-robin stage takes the hit units that are also enabled. It chooses the first such unit after the one it chose last, wrapping from the highest index back to unit 0, and remembers that choice for the next arbitration.

Top module: `ipi_target_select`

## Requirements
- R1: With shorthand `msg_cmd[19:18]` = 01 (self) and `msg_valid` high, `hit` equals `unit_src`.
- R2: With shorthand 10 (all including self) every bit of `hit` is set. With shorthand 11 (all excluding self) `hit` is the complement of `unit_src`.
- R3: With shorthand 00 and `msg_cmd[11]` = 0 (physical), a unit hits when `msg_dest` is 8'hFF or equals that unit's `unit_id` byte.
- R4: With shorthand 00, `msg_cmd[11]` = 1 (logical) and a unit's model nibble = 4'hF (flat), the unit hits when its `unit_ldr` byte ANDed with `msg_dest` is nonzero.
- R5: Under the same conditions with model nibble = 4'h0 (cluster), the unit hits when `unit_ldr[7:4]` equals `msg_dest[7:4]` and `unit_ldr[3:0] & msg_dest[3:0]` is nonzero.
- R6: In logical mode with shorthand 00, a unit whose model nibble is neither 4'hF nor 4'h0 does not hit and raises its `fmt_err` bit. `fmt_err` is low in every other case.
- R7: A write through `fmt_wr`/`fmt_wdata` stores `fmt_wdata[31:28]` as the model nibble, visible on `fmt_q` after the clock edge. Bits 27:0 of `fmt_q` always read as ones, and the reset value is 32'hFFFF_FFFF (flat).
- R8: A valid message with delivery mode `msg_cmd[10:8]` = 001 (lowest priority) makes `pick_valid` high one cycle later. `pick_onehot` then marks the first unit that is both hit and enabled, searching upward from `pick_idx`+1 with wraparound, and `pick_idx` takes that unit's index. After reset `pick_idx` is N_UNITS-1, so the first search starts at unit 0.
- R9: If no unit is both hit and enabled for such a message, `no_target` is high and `pick_onehot` is zero one cycle later, and `pick_idx` keeps its value.
- R10: While `msg_valid` is low, `hit` and `fmt_err` are all zero.
- R11: A message with any other delivery mode leaves `pick_valid`, `pick_onehot` and `no_target` low on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | Message present this cycle |
| msg_cmd | input | 32 | Command word: shorthand 19:18, mode 11, delivery 10:8 |
| msg_dest | input | 8 | Destination byte of the message |
| unit_id | input | 8*N_UNITS | Per-unit ID byte, unit i in bits 8i+7:8i |
| unit_ldr | input | 8*N_UNITS | Per-unit logical ID byte |
| unit_src | input | N_UNITS | Marks the unit(s) sending the message |
| unit_en | input | N_UNITS | Per-unit enable for lowest-priority arbitration |
| fmt_wr | input | N_UNITS | Per-unit format register write strobe |
| fmt_wdata | input | 32 | Format register write data |
| fmt_q | output | 32*N_UNITS | Per-unit format register value |
| hit | output | N_UNITS | Per-unit match result |
| fmt_err | output | N_UNITS | Per-unit undefined-model flag |
| pick_valid | output | 1 | Arbitration result present |
| pick_onehot | output | N_UNITS | Chosen unit, one-hot |
| pick_idx | output | $clog2(N_UNITS) | Index of the last chosen unit |
| no_target | output | 1 | Arbitration found no candidate |

## Verification
`hit` and `fmt_err` are combinational, so the bench drives each message just after a falling edge and samples these outputs one time unit later, in the same cycle. `fmt_q` and the arbitration outputs pass through one register. For those outputs the bench holds the stimulus across exactly one rising edge, removes it, and samples at the next falling edge, before a second edge can clear the result. The expected pointer walk, including wraparound and the held pointer on an empty candidate set, is computed by a separate search in the bench.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  typedef enum logic [1:0] {
    SH_NONE    = 2'b00,
    SH_SELF    = 2'b01,
    SH_ALL_INC = 2'b10,
    SH_ALL_EXC = 2'b11
  } shorthand_e;

  localparam int SH_LSB   = 18;
  localparam int MODE_BIT = 11;
  localparam int DLV_LSB  = 8;
  localparam logic [2:0] DLV_LOWEST    = 3'b001;
  localparam logic [3:0] MODEL_FLAT    = 4'hF;
  localparam logic [3:0] MODEL_CLUSTER = 4'h0;
  localparam logic [7:0] DEST_BCAST    = 8'hFF;

  typedef struct packed {
    logic hit;
    logic err;
  } match_t;

  function automatic match_t dest_match(
    input logic [7:0] uid,
    input logic [7:0] ldr,
    input logic [7:0] dest,
    input logic [3:0] model,
    input logic       is_src,
    input logic       logical,
    input shorthand_e sh
  );
    match_t r;
    r = '0;
    unique case (sh)
      SH_SELF:    r.hit = is_src;
      SH_ALL_INC: r.hit = 1'b1;
      SH_ALL_EXC: r.hit = ~is_src;
      default: begin
        if (!logical) begin
          r.hit = (dest == DEST_BCAST) || (dest == uid);
        end else if (model == MODEL_FLAT) begin
          r.hit = |(ldr & dest);
        end else if (model == MODEL_CLUSTER) begin
          r.hit = (ldr[7:4] == dest[7:4]) && (|(ldr[3:0] & dest[3:0]));
        end else begin
          r.err = 1'b1;
        end
      end
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ipi_unit_match.sv
module ipi_unit_match
  import ipi_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        fmt_wr,
  input  logic [31:0] fmt_wdata,
  input  logic [7:0]  uid,
  input  logic [7:0]  ldr,
  input  logic        is_src,
  input  logic        msg_valid,
  input  logic [7:0]  dest,
  input  logic        logical,
  input  shorthand_e  sh,
  output logic [31:0] fmt_q,
  output logic        hit,
  output logic        err
);

  logic [3:0] model_q;
  match_t     res;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      model_q <= MODEL_FLAT;
    end else if (fmt_wr) begin
      model_q <= fmt_wdata[31:28];
    end
  end

  assign fmt_q = {model_q, {28{1'b1}}};

  always_comb begin
    res = dest_match(uid, ldr, dest, model_q, is_src, logical, sh);
  end

  assign hit = msg_valid & res.hit;
  assign err = msg_valid & res.err;

endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [N-1:0]  cand,
  output logic          pick_valid,
  output logic [N-1:0]  pick_onehot,
  output logic [IW-1:0] pick_idx,
  output logic          no_target
);

  logic [IW-1:0] next_idx;

  function automatic logic [IW-1:0] search_after(
    input logic [N-1:0]  c,
    input logic [IW-1:0] last
  );
    logic [IW-1:0] found;
    logic          got;
    found = last;
    got   = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last) + k) % N;
      if (!got && c[idx]) begin
        found = IW'(idx);
        got   = 1'b1;
      end
    end
    return found;
  endfunction

  always_comb begin
    next_idx = search_after(cand, pick_idx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pick_valid  <= 1'b0;
      pick_onehot <= '0;
      pick_idx    <= IW'(N - 1);
      no_target   <= 1'b0;
    end else if (req) begin
      pick_valid <= 1'b1;
      if (|cand) begin
        pick_onehot <= N'(1) << next_idx;
        pick_idx    <= next_idx;
        no_target   <= 1'b0;
      end else begin
        pick_onehot <= '0;
        no_target   <= 1'b1;
      end
    end else begin
      pick_valid  <= 1'b0;
      pick_onehot <= '0;
      no_target   <= 1'b0;
    end
  end

endmodule

// File: rtl/ipi_target_select.sv
module ipi_target_select
  import ipi_pkg::*;
#(
  parameter int N_UNITS = 8,
  localparam int IW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msg_valid,
  input  logic [31:0]          msg_cmd,
  input  logic [7:0]           msg_dest,
  input  logic [8*N_UNITS-1:0] unit_id,
  input  logic [8*N_UNITS-1:0] unit_ldr,
  input  logic [N_UNITS-1:0]   unit_src,
  input  logic [N_UNITS-1:0]   unit_en,
  input  logic [N_UNITS-1:0]   fmt_wr,
  input  logic [31:0]          fmt_wdata,
  output logic [32*N_UNITS-1:0] fmt_q,
  output logic [N_UNITS-1:0]   hit,
  output logic [N_UNITS-1:0]   fmt_err,
  output logic                 pick_valid,
  output logic [N_UNITS-1:0]   pick_onehot,
  output logic [IW-1:0]        pick_idx,
  output logic                 no_target
);

  shorthand_e           sh_w;
  logic                 logical_w;
  logic                 lp_req_w;
  logic [N_UNITS-1:0]   cand_w;

  assign sh_w      = shorthand_e'(msg_cmd[SH_LSB +: 2]);
  assign logical_w = msg_cmd[MODE_BIT];
  assign lp_req_w  = msg_valid && (msg_cmd[DLV_LSB +: 3] == DLV_LOWEST);
  assign cand_w    = hit & unit_en;

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    ipi_unit_match u_match (
      .clk       (clk),
      .rst_n     (rst_n),
      .fmt_wr    (fmt_wr[i]),
      .fmt_wdata (fmt_wdata),
      .uid       (unit_id[8*i +: 8]),
      .ldr       (unit_ldr[8*i +: 8]),
      .is_src    (unit_src[i]),
      .msg_valid (msg_valid),
      .dest      (msg_dest),
      .logical   (logical_w),
      .sh        (sh_w),
      .fmt_q     (fmt_q[32*i +: 32]),
      .hit       (hit[i]),
      .err       (fmt_err[i])
    );
  end

  ipi_rr_pick #(.N(N_UNITS)) u_pick (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (lp_req_w),
    .cand        (cand_w),
    .pick_valid  (pick_valid),
    .pick_onehot (pick_onehot),
    .pick_idx    (pick_idx),
    .no_target   (no_target)
  );

endmodule

// File: rtl/ipi_target_select_chk.sv
module ipi_target_select_chk #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          msg_valid,
  input logic [31:0]   msg_cmd,
  input logic [N-1:0]  unit_src,
  input logic [N-1:0]  hit,
  input logic [N-1:0]  fmt_err,
  input logic          pick_valid,
  input logic [N-1:0]  pick_onehot,
  input logic [IW-1:0] pick_idx,
  input logic          no_target,
  input logic [N-1:0]  cand_w,
  input logic          lp_req_w
);

  a_r1_self_only: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_cmd[19:18] == 2'b01) |-> (hit == unit_src));

  a_r2_all_but_src: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_cmd[19:18] == 2'b11) |-> (hit == ~unit_src));

  a_r6_err_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & fmt_err) == '0);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |-> (hit == '0 && fmt_err == '0));

  a_r8_onehot_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_onehot));

  a_r8_pick_was_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req_w && (cand_w != '0) |=> (pick_valid && (pick_onehot & $past(cand_w)) != '0));

  a_r9_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req_w && (cand_w == '0) |=> (no_target && $stable(pick_idx)));

  a_r11_no_pick_without_lowest: assert property (@(posedge clk) disable iff (!rst_n)
    !lp_req_w |=> (!pick_valid && !no_target && pick_onehot == '0));

endmodule

bind ipi_target_select ipi_target_select_chk #(.N(N_UNITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .msg_cmd     (msg_cmd),
  .unit_src    (unit_src),
  .hit         (hit),
  .fmt_err     (fmt_err),
  .pick_valid  (pick_valid),
  .pick_onehot (pick_onehot),
  .pick_idx    (pick_idx),
  .no_target   (no_target),
  .cand_w      (cand_w),
  .lp_req_w    (lp_req_w)
);

// File: tb/sim_ipi_target_select.sv
`timescale 1ns/1ps
module sim_ipi_target_select;

  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic               clk = 1'b0;
  logic               rst_n;
  logic               msg_valid;
  logic [31:0]        msg_cmd;
  logic [7:0]         msg_dest;
  logic [8*N-1:0]     unit_id;
  logic [8*N-1:0]     unit_ldr;
  logic [N-1:0]       unit_src;
  logic [N-1:0]       unit_en;
  logic [N-1:0]       fmt_wr;
  logic [31:0]        fmt_wdata;
  logic [32*N-1:0]    fmt_q;
  logic [N-1:0]       hit;
  logic [N-1:0]       fmt_err;
  logic               pick_valid;
  logic [N-1:0]       pick_onehot;
  logic [IW-1:0]      pick_idx;
  logic               no_target;

  int n_checks = 0;
  int n_fail   = 0;
  logic [3:0] b_model [N];
  int b_ptr;

  always #5 clk = ~clk;

  ipi_target_select #(.N_UNITS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_cmd(msg_cmd),
    .msg_dest(msg_dest), .unit_id(unit_id), .unit_ldr(unit_ldr),
    .unit_src(unit_src), .unit_en(unit_en), .fmt_wr(fmt_wr),
    .fmt_wdata(fmt_wdata), .fmt_q(fmt_q), .hit(hit), .fmt_err(fmt_err),
    .pick_valid(pick_valid), .pick_onehot(pick_onehot), .pick_idx(pick_idx),
    .no_target(no_target)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcmd(input logic [1:0] sh, input logic lg, input logic [2:0] dm);
    logic [31:0] c;
    c = 32'h0;
    c[19:18] = sh;
    c[11] = lg;
    c[10:8] = dm;
    return c;
  endfunction

  function automatic logic ref_hit(input int i, input logic [1:0] sh, input logic lg, input logic [7:0] d);
    logic [7:0] l;
    l = unit_ldr[8*i +: 8];
    if (sh == 2'b01) return unit_src[i];
    if (sh == 2'b10) return 1'b1;
    if (sh == 2'b11) return !unit_src[i];
    if (!lg) return (d == 8'hFF) || (d == unit_id[8*i +: 8]);
    if (b_model[i] == 4'hF) return (l & d) != 8'h0;
    if (b_model[i] == 4'h0) return (l[7:4] == d[7:4]) && ((l[3:0] & d[3:0]) != 4'h0);
    return 1'b0;
  endfunction

  function automatic logic ref_err(input int i, input logic [1:0] sh, input logic lg);
    return (sh == 2'b00) && lg && (b_model[i] != 4'hF) && (b_model[i] != 4'h0);
  endfunction

  task automatic write_fmt(input logic [N-1:0] which, input logic [31:0] w);
    @(negedge clk);
    fmt_wr = which;
    fmt_wdata = w;
    @(negedge clk);
    fmt_wr = '0;
    for (int i = 0; i < N; i++) if (which[i]) b_model[i] = w[31:28];
    #1;
  endtask

  task automatic t_match(input string req, input logic [1:0] sh, input logic lg, input logic [7:0] d);
    logic [N-1:0] eh, ee;
    @(negedge clk);
    msg_valid = 1'b1;
    msg_cmd = mkcmd(sh, lg, 3'b000);
    msg_dest = d;
    #1;
    for (int i = 0; i < N; i++) begin
      eh[i] = ref_hit(i, sh, lg, d);
      ee[i] = ref_err(i, sh, lg);
    end
    chk({req, " hit"}, 64'(hit), 64'(eh));
    chk({req, " err"}, 64'(fmt_err), 64'(ee));
    @(negedge clk);
    msg_valid = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10 reset hit", 64'(hit), 64'h0);
    chk("R8 reset pick_idx", 64'(pick_idx), 64'(N - 1));
    chk("R11 reset pick", 64'({pick_valid, no_target, pick_onehot}), 64'h0);
    for (int i = 0; i < N; i++) chk("R7 reset fmt", 64'(fmt_q[32*i +: 32]), 64'hFFFF_FFFF);
  endtask

  task automatic t_fmt;
    write_fmt(8'h01, 32'h0000_1234);
    chk("R7 write low bits forced", 64'(fmt_q[31:0]), 64'h0FFF_FFFF);
    chk("R7 neighbour untouched", 64'(fmt_q[63:32]), 64'hFFFF_FFFF);
    write_fmt(8'h01, 32'hF000_0000);
    chk("R7 restore flat", 64'(fmt_q[31:0]), 64'hFFFF_FFFF);
  endtask

  task automatic t_idle;
    @(negedge clk);
    msg_valid = 1'b0;
    msg_cmd = mkcmd(2'b10, 1'b0, 3'b000);
    msg_dest = 8'hFF;
    #1;
    chk("R10 idle hit", 64'(hit), 64'h0);
    chk("R10 idle err", 64'(fmt_err), 64'h0);
  endtask

  task automatic t_lowest(input string req, input logic [7:0] d, input logic [N-1:0] en);
    logic [N-1:0] cand;
    logic [N-1:0] eoh;
    int nxt;
    logic empty;
    @(negedge clk);
    unit_en = en;
    msg_valid = 1'b1;
    msg_cmd = mkcmd(2'b00, 1'b0, 3'b001);
    msg_dest = d;
    #1;
    for (int i = 0; i < N; i++) cand[i] = ref_hit(i, 2'b00, 1'b0, d) & en[i];
    empty = (cand == '0);
    nxt = b_ptr;
    if (!empty) begin
      for (int k = N; k >= 1; k--) if (cand[(b_ptr + k) % N]) nxt = (b_ptr + k) % N;
    end
    eoh = empty ? '0 : (N'(1) << nxt);
    @(negedge clk);
    msg_valid = 1'b0;
    #1;
    chk({req, " valid"}, 64'(pick_valid), 64'h1);
    chk({req, " no_target"}, 64'(no_target), 64'(empty));
    chk({req, " onehot"}, 64'(pick_onehot), 64'(eoh));
    chk({req, " idx"}, 64'(pick_idx), 64'(nxt));
    b_ptr = nxt;
  endtask

  task automatic t_fixed;
    @(negedge clk);
    unit_en = '1;
    msg_valid = 1'b1;
    msg_cmd = mkcmd(2'b00, 1'b0, 3'b000);
    msg_dest = 8'hFF;
    @(negedge clk);
    msg_valid = 1'b0;
    #1;
    chk("R11 fixed no pick", 64'({pick_valid, no_target, pick_onehot}), 64'h0);
    chk("R11 fixed idx kept", 64'(pick_idx), 64'(b_ptr));
  endtask

  initial begin
    rst_n = 1'b0;
    msg_valid = 1'b0;
    msg_cmd = '0;
    msg_dest = '0;
    unit_en = '0;
    fmt_wr = '0;
    fmt_wdata = '0;
    unit_src = 8'b0000_0100;
    for (int i = 0; i < N; i++) begin
      unit_id[8*i +: 8] = 8'h20 + 8'(i);
      unit_ldr[8*i +: 8] = 8'(1) << i;
      b_model[i] = 4'hF;
    end
    b_ptr = N - 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    t_reset();
    t_fmt();
    t_idle();
    t_match("R3 physical id", 2'b00, 1'b0, 8'h23);
    t_match("R3 physical bcast", 2'b00, 1'b0, 8'hFF);
    t_match("R3 physical none", 2'b00, 1'b0, 8'h99);
    t_match("R4 flat", 2'b00, 1'b1, 8'h0A);
    t_match("R1 self", 2'b01, 1'b0, 8'h00);
    t_match("R2 all incl", 2'b10, 1'b0, 8'h00);
    t_match("R2 all excl", 2'b11, 1'b1, 8'h00);

    write_fmt('1, 32'h0FFF_FFFF);
    for (int i = 0; i < N; i++) unit_ldr[8*i +: 8] = {4'(i / 4), 4'(1) << (i % 4)};
    t_match("R5 cluster one", 2'b00, 1'b1, 8'h13);
    t_match("R5 cluster zero", 2'b00, 1'b1, 8'h03);
    t_match("R5 cluster none", 2'b00, 1'b1, 8'h2F);
    write_fmt(8'h40, 32'h5000_0000);
    t_match("R6 undefined logical", 2'b00, 1'b1, 8'h1F);
    t_match("R6 undefined physical", 2'b00, 1'b0, 8'hFF);

    write_fmt('1, 32'hFFFF_FFFF);
    for (int i = 0; i < N; i++) unit_ldr[8*i +: 8] = 8'(1) << i;
    t_lowest("R8 first", 8'hFF, '1);
    t_lowest("R8 second", 8'hFF, '1);
    t_lowest("R8 third", 8'hFF, '1);
    t_lowest("R8 matched subset", 8'h23, '1);
    t_lowest("R8 skip", 8'hFF, 8'b0010_0010);
    t_lowest("R8 wrap", 8'hFF, 8'b0010_0010);
    t_lowest("R9 empty", 8'hFF, 8'h00);
    t_lowest("R9 unmatched", 8'h99, '1);
    t_fixed();

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule